// File: doc/BRIEF.md
# SD Host Interrupt Status and Masking Unit

This block gathers every interrupt source of an SD host controller in one place. The command and data engines report events as one-cycle pulses: command done, data over, CRC errors, timeouts, bit errors and the locked error. A card-detect change, which the block finds itself from the synchronized card-detect pins, also counts as an event. Each event sets a bit in a 16-bit raw status register. Software clears a bit by writing a one to it. A mask register picks which raw bits reach the masked status. A global enable then decides whether the single interrupt output is driven.

For each slot the block also senses the SDIO card interrupt. It watches a combined active-low request, formed from the synchronized D1 line, a per-slot gate input and the synchronized card-detect pin. The per-slot status bit is set once on each falling edge of that request and is not set again while the request stays low. These bits have their own mask and are cleared by writing ones.

A separate 5-bit DMA status register has its own clear-by-writing-ones and three enables: normal, receive and transmit. All control and status pins are plain levels and strobes. There is no streaming interface, so there is no back-pressure.

Top module: `sd_irq_unit`

## Requirements
- R1: A pulse on `evt_pulse[i]` sets `raw_status[i]` at the next clock edge. `raw_status[i]` stays set until a write with `raw_clr_we` high and a one in `raw_clr_data[i]` clears it at that edge. Clear bits that are zero have no effect.
- R2: If an event pulse and a clear of the same bit fall in the same cycle, the bit stays set. This holds for the raw, SDIO and DMA status registers.
- R3: `masked_status` equals `raw_status` AND the mask register. A mask write (`mask_we`) takes effect at the clock edge where it is written.
- R4: `irq` is high only when the global enable is 1 and at least one of these holds: `masked_status` is non-zero, `sdio_masked` is non-zero, or the DMA group requests an interrupt (R11).
- R5: After reset, every status register is 0, the mask, the SDIO mask, the DMA enables and the global enable are 0, and `irq` is low.
- R6: Writing the value read from `masked_status` back through the raw clear clears exactly the masked bits. It leaves every unmasked pending bit set.
- R7: Any change of a synchronized `cd_n` bit sets `raw_status[0]` (the card-detect bit). With a 2-stage synchronizer, a pin change made before clock edge k shows in the status after edge k+2 and not after edge k+1. A steady `cd_n` sets nothing.
- R8: `sdio_status[s]` is set on a falling edge of the request term (synchronized `d1_in[s]` OR `sdio_gate_n[s]` OR synchronized `cd_n[s]`). When `d1_in` falls, the bit appears after edge k+2. When `sdio_gate_n` falls while the other inputs are already low, the bit appears at the next edge. Holding the request low after a clear does not set the bit again. While `sdio_gate_n[s]` is high, the bit is not set.
- R9: `sdio_masked` equals `sdio_status` AND the SDIO mask. A one in `sdio_clr_data` clears the matching SDIO status bit when `sdio_clr_we` is high.
- R10: `dma_status` is a separate 5-bit register. It is set by `dma_evt_pulse` and cleared by `dma_clr_we`/`dma_clr_data` writing ones.
- R11: The DMA enables are written through `dma_en_wdata`: bit 2 is normal, bit 1 is receive, bit 0 is transmit. The DMA group requests an interrupt when normal is set and any of these holds: `dma_status[0]` (transmit done) with transmit enabled, `dma_status[1]` (receive done) with receive enabled, or any of the error bits `dma_status[4:2]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| evt_pulse | input | 16 | Controller event pulses, one per raw status bit |
| cd_n | input | 2 | Card-detect pins per slot, low means card present (asynchronous) |
| d1_in | input | 2 | D1 data line per slot (asynchronous) |
| sdio_gate_n | input | 2 | Per-slot SDIO request gate, low lets D1 through |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 16 | New mask value |
| gie_we | input | 1 | Global enable write strobe |
| gie_wdata | input | 1 | New global enable value |
| raw_clr_we | input | 1 | Raw status clear strobe |
| raw_clr_data | input | 16 | Ones clear the matching raw bits |
| sdio_mask_we | input | 1 | SDIO mask write strobe |
| sdio_mask_wdata | input | 2 | New SDIO mask value |
| sdio_clr_we | input | 1 | SDIO status clear strobe |
| sdio_clr_data | input | 2 | Ones clear the matching SDIO bits |
| dma_evt_pulse | input | 5 | DMA event pulses |
| dma_clr_we | input | 1 | DMA status clear strobe |
| dma_clr_data | input | 5 | Ones clear the matching DMA bits |
| dma_en_we | input | 1 | DMA enable write strobe |
| dma_en_wdata | input | 3 | {normal, receive, transmit} enables |
| raw_status | output | 16 | Raw status |
| masked_status | output | 16 | Raw status AND mask |
| sdio_status | output | 2 | SDIO interrupt status per slot |
| sdio_masked | output | 2 | SDIO status AND SDIO mask |
| dma_status | output | 5 | DMA status |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the following corner cases:
- **Event and clear in the same cycle.** A design that lets the clear win would silently lose that event.
- **Card-detect and D1 latency.** Checks are placed one edge before and one edge after the synchronizer delay. A missing or extra stage shows up as an early or late status bit.
- **D1 held low after a clear.** A level-sensitive detector would set the SDIO bit again on every cycle.
- **Gate released while D1 is already low.** This must still produce exactly one edge.
- **Write-back acknowledge and DMA enable mapping.** These are tested so that a clear reaching unmasked bits, or an enable wired to the wrong DMA bit, changes the observed status or `irq`.

// File: rtl/sd_irq_pkg.sv
package sd_irq_pkg;
  localparam int unsigned DMA_W    = 5;
  localparam int unsigned DMA_TX   = 0;
  localparam int unsigned DMA_RX   = 1;
  localparam int unsigned DMA_ERRL = 2;

  typedef struct packed {
    logic norm;
    logic rx;
    logic tx;
  } dma_en_t;
endpackage

// File: rtl/sd_irq_sync.sv
module sd_irq_sync #(
  parameter int unsigned W       = 2,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_BIT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= {STAGES{{W{RST_BIT}}}};
    end else begin
      stg[0] <= din;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/sd_irq_w1c_reg.sv
module sd_irq_w1c_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic         clr_we,
  input  logic [W-1:0] clr_data,
  output logic [W-1:0] q
);
  logic [W-1:0] clr_eff;

  always_comb clr_eff = clr_we ? clr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr_eff) | set;
  end

  assert_set_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> ((q & $past(set)) == $past(set)));

  assert_w1c_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && ((clr_data & ~set) != '0)) |=> ((q & $past(clr_data & ~set)) == '0));
endmodule

// File: rtl/sd_irq_line_sense.sv
module sd_irq_line_sense #(
  parameter int unsigned NSLOT  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] cd_n,
  input  logic [NSLOT-1:0] d1_in,
  input  logic [NSLOT-1:0] sdio_gate_n,
  output logic             cd_chg,
  output logic [NSLOT-1:0] sdio_fall
);
  logic [NSLOT-1:0] cd_s, cd_prev, d1_s, req_n, req_prev;

  sd_irq_sync #(.W(NSLOT), .STAGES(STAGES), .RST_BIT(1'b0)) u_cd_sync (
    .clk(clk), .rst_n(rst_n), .din(cd_n), .dout(cd_s));

  sd_irq_sync #(.W(NSLOT), .STAGES(STAGES), .RST_BIT(1'b1)) u_d1_sync (
    .clk(clk), .rst_n(rst_n), .din(d1_in), .dout(d1_s));

  always_comb req_n = d1_s | sdio_gate_n | cd_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cd_prev  <= '0;
      req_prev <= '0;
    end else begin
      cd_prev  <= cd_s;
      req_prev <= req_n;
    end
  end

  assign cd_chg = |(cd_s ^ cd_prev);

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign sdio_fall[s] = req_prev[s] & ~req_n[s];
  end

  assert_sdio_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sdio_fall != '0) |=> ((sdio_fall & $past(sdio_fall)) == '0));
endmodule

// File: rtl/sd_irq_unit.sv
module sd_irq_unit
  import sd_irq_pkg::*;
#(
  parameter int unsigned NEVT   = 16,
  parameter int unsigned NSLOT  = 2,
  parameter int unsigned STAGES = 2,
  parameter int unsigned CD_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NEVT-1:0]   evt_pulse,
  input  logic [NSLOT-1:0]  cd_n,
  input  logic [NSLOT-1:0]  d1_in,
  input  logic [NSLOT-1:0]  sdio_gate_n,
  input  logic              mask_we,
  input  logic [NEVT-1:0]   mask_wdata,
  input  logic              gie_we,
  input  logic              gie_wdata,
  input  logic              raw_clr_we,
  input  logic [NEVT-1:0]   raw_clr_data,
  input  logic              sdio_mask_we,
  input  logic [NSLOT-1:0]  sdio_mask_wdata,
  input  logic              sdio_clr_we,
  input  logic [NSLOT-1:0]  sdio_clr_data,
  input  logic [DMA_W-1:0]  dma_evt_pulse,
  input  logic              dma_clr_we,
  input  logic [DMA_W-1:0]  dma_clr_data,
  input  logic              dma_en_we,
  input  logic [2:0]        dma_en_wdata,
  output logic [NEVT-1:0]   raw_status,
  output logic [NEVT-1:0]   masked_status,
  output logic [NSLOT-1:0]  sdio_status,
  output logic [NSLOT-1:0]  sdio_masked,
  output logic [DMA_W-1:0]  dma_status,
  output logic              irq
);
  logic              cd_chg;
  logic [NSLOT-1:0]  sdio_fall;
  logic [NEVT-1:0]   raw_set;
  logic [NEVT-1:0]   mask_q;
  logic [NSLOT-1:0]  sdio_mask_q;
  logic              gie_q;
  dma_en_t           dma_en_q;
  logic              dma_hit;

  sd_irq_line_sense #(.NSLOT(NSLOT), .STAGES(STAGES)) u_sense (
    .clk(clk), .rst_n(rst_n), .cd_n(cd_n), .d1_in(d1_in),
    .sdio_gate_n(sdio_gate_n), .cd_chg(cd_chg), .sdio_fall(sdio_fall));

  always_comb begin
    raw_set         = evt_pulse;
    raw_set[CD_BIT] = evt_pulse[CD_BIT] | cd_chg;
  end

  sd_irq_w1c_reg #(.W(NEVT)) u_raw (
    .clk(clk), .rst_n(rst_n), .set(raw_set),
    .clr_we(raw_clr_we), .clr_data(raw_clr_data), .q(raw_status));

  sd_irq_w1c_reg #(.W(NSLOT)) u_sdio (
    .clk(clk), .rst_n(rst_n), .set(sdio_fall),
    .clr_we(sdio_clr_we), .clr_data(sdio_clr_data), .q(sdio_status));

  sd_irq_w1c_reg #(.W(DMA_W)) u_dma (
    .clk(clk), .rst_n(rst_n), .set(dma_evt_pulse),
    .clr_we(dma_clr_we), .clr_data(dma_clr_data), .q(dma_status));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q      <= '0;
      sdio_mask_q <= '0;
      gie_q       <= 1'b0;
      dma_en_q    <= '0;
    end else begin
      if (mask_we)      mask_q      <= mask_wdata;
      if (sdio_mask_we) sdio_mask_q <= sdio_mask_wdata;
      if (gie_we)       gie_q       <= gie_wdata;
      if (dma_en_we)    dma_en_q    <= dma_en_t'(dma_en_wdata);
    end
  end

  assign masked_status = raw_status & mask_q;
  assign sdio_masked   = sdio_status & sdio_mask_q;

  always_comb begin
    dma_hit = dma_en_q.norm &
              ((dma_status[DMA_TX] & dma_en_q.tx) |
               (dma_status[DMA_RX] & dma_en_q.rx) |
               (|dma_status[DMA_W-1:DMA_ERRL]));
  end

  assign irq = gie_q & ((|masked_status) | (|sdio_masked) | dma_hit);

  assert_cd_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cd_chg |=> raw_status[CD_BIT]);

  assert_ack_exact_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_clr_we && raw_clr_data == masked_status && raw_set == '0 && !mask_we)
      |=> (raw_status == ($past(raw_status) & ~$past(mask_q))));
endmodule

// File: tb/tb_sd_irq_unit.sv
module tb_sd_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt_pulse = '0;
  logic [1:0]  cd_n = '0, d1_in = '1, sdio_gate_n = '0;
  logic        mask_we = 0, gie_we = 0, gie_wdata = 0, raw_clr_we = 0;
  logic [15:0] mask_wdata = '0, raw_clr_data = '0;
  logic        sdio_mask_we = 0, sdio_clr_we = 0, dma_clr_we = 0, dma_en_we = 0;
  logic [1:0]  sdio_mask_wdata = '0, sdio_clr_data = '0;
  logic [4:0]  dma_evt_pulse = '0, dma_clr_data = '0;
  logic [2:0]  dma_en_wdata = '0;
  logic [15:0] raw_status, masked_status;
  logic [1:0]  sdio_status, sdio_masked;
  logic [4:0]  dma_status;
  logic        irq;

  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sd_irq_unit dut (.*);

  // evt, clr, mask, gie | exp raw, exp masked, exp irq
  localparam int VW = 82;
  localparam logic [VW-1:0] VEC [8] = '{
    {16'h0006, 16'h0000, 16'h0002, 1'b1, 16'h0006, 16'h0002, 1'b1},
    {16'h0000, 16'h0002, 16'h0002, 1'b1, 16'h0004, 16'h0000, 1'b0},
    {16'h0004, 16'h0004, 16'h0004, 1'b1, 16'h0004, 16'h0004, 1'b1},
    {16'h8000, 16'h0000, 16'hFFFF, 1'b0, 16'h8004, 16'h8004, 1'b0},
    {16'h0000, 16'h0000, 16'hFFFF, 1'b1, 16'h8004, 16'h8004, 1'b1},
    {16'h0100, 16'h8004, 16'h0100, 1'b1, 16'h0100, 16'h0100, 1'b1},
    {16'h0000, 16'hFFFF, 16'h0100, 1'b1, 16'h0000, 16'h0000, 1'b0},
    {16'h00F0, 16'h000F, 16'h00A0, 1'b1, 16'h00F0, 16'h00A0, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic raw_clr(input logic [15:0] v);
    raw_clr_we = 1; raw_clr_data = v; tick(1); raw_clr_we = 0; raw_clr_data = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(2);
    // R5 reset state
    chk("R5 raw", raw_status, 0);
    chk("R5 masked", masked_status, 0);
    chk("R5 sdio", sdio_status, 0);
    chk("R5 dma", dma_status, 0);
    chk("R5 irq", irq, 0);
    evt_pulse = 16'h0010; tick(1); evt_pulse = '0;
    chk("R5 mask zero after reset", masked_status, 0);
    chk("R5 gie zero after reset", irq, 0);
    raw_clr(16'hFFFF);
    chk("R1 clear all", raw_status, 0);

    // table: R1 R2 R3 R4
    for (int i = 0; i < 8; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      evt_pulse = v[81:66]; raw_clr_we = 1; raw_clr_data = v[65:50];
      mask_we = 1; mask_wdata = v[49:34]; gie_we = 1; gie_wdata = v[33];
      tick(1);
      evt_pulse = '0; raw_clr_we = 0; raw_clr_data = '0; mask_we = 0; gie_we = 0;
      chk($sformatf("R1/R2 raw vec%0d", i), raw_status, v[32:17]);
      chk($sformatf("R3 masked vec%0d", i), masked_status, v[16:1]);
      chk($sformatf("R4 irq vec%0d", i), irq, v[0]);
    end

    // R6 write-back acknowledge
    raw_clr(16'hFFFF);
    evt_pulse = 16'h0A0A; mask_we = 1; mask_wdata = 16'h000A; tick(1);
    evt_pulse = '0; mask_we = 0;
    raw_clr(masked_status);
    chk("R6 ack leaves unmasked", raw_status, 16'h0A00);
    chk("R6 irq after ack", irq, 0);
    raw_clr(16'hFFFF);
    mask_we = 1; mask_wdata = '0; tick(1); mask_we = 0;

    // R7 card detect
    cd_n[0] = 1'b1;
    tick(2);
    chk("R7 cd not yet", raw_status[0], 0);
    tick(1);
    chk("R7 cd set", raw_status[0], 1);
    raw_clr(16'h0001);
    chk("R7 cd cleared", raw_status[0], 0);
    tick(3);
    chk("R7 steady cd no set", raw_status[0], 0);
    cd_n[0] = 1'b0;
    tick(3);
    chk("R7 cd set on return", raw_status[0], 1);
    raw_clr(16'h0001);
    tick(3);

    // R8 R9 SDIO
    sdio_mask_we = 1; sdio_mask_wdata = 2'b10; tick(1); sdio_mask_we = 0;
    d1_in[1] = 1'b0;
    tick(2);
    chk("R8 sdio not yet", sdio_status, 2'b00);
    tick(1);
    chk("R8 sdio set", sdio_status, 2'b10);
    chk("R9 sdio masked", sdio_masked, 2'b10);
    chk("R4 irq from sdio", irq, 1);
    sdio_clr_we = 1; sdio_clr_data = 2'b10; tick(1); sdio_clr_we = 0; sdio_clr_data = '0;
    chk("R9 sdio cleared", sdio_status, 2'b00);
    tick(5);
    chk("R8 held low no reset", sdio_status, 2'b00);
    chk("R4 irq idle", irq, 0);
    d1_in[1] = 1'b1; tick(3);
    d1_in[1] = 1'b0; tick(3);
    chk("R8 second edge", sdio_status, 2'b10);
    sdio_gate_n[0] = 1'b1; d1_in[0] = 1'b0;
    tick(4);
    chk("R8 gated no set", sdio_status[0], 0);
    sdio_gate_n[0] = 1'b0;
    tick(1);
    chk("R8 gate release edge", sdio_status[0], 1);
    chk("R9 unmasked slot", sdio_masked, 2'b10);
    sdio_clr_we = 1; sdio_clr_data = 2'b11; tick(1); sdio_clr_we = 0;
    chk("R9 clear both", sdio_status, 2'b00);

    // R10 R11 DMA
    chk("R11 irq before dma", irq, 0);
    dma_en_we = 1; dma_en_wdata = 3'b101; dma_evt_pulse = 5'b00001; tick(1);
    dma_en_we = 0; dma_evt_pulse = '0;
    chk("R10 dma set", dma_status, 5'b00001);
    chk("R11 tx enabled irq", irq, 1);
    dma_en_we = 1; dma_en_wdata = 3'b110; tick(1); dma_en_we = 0;
    chk("R11 tx disabled", irq, 0);
    dma_en_we = 1; dma_en_wdata = 3'b011; dma_evt_pulse = 5'b01000; tick(1);
    dma_en_we = 0; dma_evt_pulse = '0;
    chk("R11 normal off", irq, 0);
    dma_en_we = 1; dma_en_wdata = 3'b100; tick(1); dma_en_we = 0;
    chk("R11 error bit irq", irq, 1);
    dma_clr_we = 1; dma_clr_data = 5'b11111; dma_evt_pulse = 5'b00010; tick(1);
    dma_clr_we = 0; dma_clr_data = '0; dma_evt_pulse = '0;
    chk("R10 R2 dma set wins", dma_status, 5'b00010);
    chk("R11 rx not enabled", irq, 0);
    dma_en_we = 1; dma_en_wdata = 3'b110; tick(1); dma_en_we = 0;
    chk("R11 rx enabled", irq, 1);
    gie_we = 1; gie_wdata = 0; tick(1); gie_we = 0;
    chk("R4 gie off", irq, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule